// File: doc/BRIEF.md
# Slow-Clock Serial Memory Streamer

This block sends the whole contents of a 128-byte memory, without end, onto a shared open-drain data line. Each bit is paced by a rising edge of a slow external clock that is unrelated to the system clock. That clock is brought into the system clock domain through a synchronizer, and its rising edges are detected there. After reset the block stays silent for a warm-up of nine slow-clock rising edges. It then emits each byte with the most significant bit first, followed by a ninth slot in which the line is released. The bytes go out in address order, and after the last address the sequence starts again at address zero.

A mode controller owns the enable input. When the enable drops, the line is released at once and the stream position returns to the start. When the enable returns, the stream resumes from the first bit of address zero. The warm-up is not repeated once it has finished. The memory is read through a plain read port. The block presents the address of the next byte well ahead of the slow-clock edge that loads that byte.

Top module: `vclk_stream_tx`

## Requirements
- R1: While and just after reset, `sda_oe` is 0 and `rd_addr` is 0.
- R2: The first nine slow-clock rising edges seen while `en` is 1 leave `sda_oe` at 0. Edges seen while `en` is 0 do not count toward the nine.
- R3: On the tenth counted rising edge, `sda_oe` becomes 1 and `sda_out` carries bit 7 of the byte at address 0.
- R4: Each byte takes nine rising edges. The first eight drive bits 7 down to 0 on `sda_out` with `sda_oe`=1, and the ninth releases the line (`sda_oe`=0).
- R5: After the byte at address 127 has been sent, the next byte sent is the one at address 0, with no extra edge between them.
- R6: An output update becomes visible after the third rising system-clock edge that follows `vclk_in` going high. Between updates, `sda_oe`, `sda_out` and `rd_addr` hold, whatever the high and low durations of `vclk_in`.
- R7: While `en` is 0, `sda_oe` is 0 in the same cycle, rising edges are ignored, and from the next cycle on `rd_addr` is 0.
- R8: When `en` returns to 1 after the warm-up has completed, the next rising edge drives bit 7 of address 0. No warm-up is repeated.
- R9: `rd_addr` holds the address of the next byte to be loaded. It advances by one (modulo 128) in the same cycle in which that byte's bit 7 appears. `rd_data` is sampled only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vclk_in | input | 1 | Slow bit clock, asynchronous to `clk` |
| en | input | 1 | Streaming enable from the mode controller |
| rd_addr | output | 7 | Memory read address (next byte to load) |
| rd_data | input | 8 | Memory read data for `rd_addr` |
| sda_oe | output | 1 | Drive enable for the open-drain data line |
| sda_out | output | 1 | Data value while `sda_oe` is 1 |

## Verification
The stream is driven with a fast, regular bit clock through a full pass of the memory and past the wrap. This separates a correct wrap and null slot from an off-by-one in the byte or bit count. A stretched pattern with long high and low phases shows whether outputs move on anything other than a rising edge. Toggling the enable during the warm-up, and again in the middle of a byte, distinguishes a warm-up counter that holds from one that restarts or runs on. It also shows whether the restart resumes at bit 7 of address 0 or at a stale position. Memory contents differ per address and have bit 7 set at address 0, so a wrong address or bit order shows up on the line.

// File: rtl/vst_pkg.sv
package vst_pkg;

    localparam int unsigned VST_DEPTH       = 128;
    localparam int unsigned VST_DATA_W      = 8;
    localparam int unsigned VST_WARM_RISES  = 9;
    localparam int unsigned VST_SYNC_STAGES = 2;

    // What the serializer does on an accepted slow-clock edge
    typedef enum logic [1:0] {
        STEP_LOAD  = 2'd0,   // fetch a new byte, drive its MSB
        STEP_SHIFT = 2'd1,   // move to the next lower bit
        STEP_GAP   = 2'd2    // release the line for the null slot
    } step_e;

    // Registered serializer state
    typedef struct packed {
        logic        drive;
        logic [3:0]  slot;   // 0..DATA_W-1 data, DATA_W gap/idle
    } ser_state_t;

    function automatic int unsigned wrap_inc(input int unsigned a, input int unsigned depth);
        return (a + 1 >= depth) ? 0 : a + 1;
    endfunction

endpackage

// File: rtl/vst_edge_sync.sv
module vst_edge_sync #(
    parameter int unsigned STAGES = vst_pkg::VST_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 1'b0;
            else     chain[g] <= (g == 0) ? async_in : chain[(g == 0) ? 0 : g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/vst_warmup.sv
module vst_warmup #(
    parameter int unsigned RISES = vst_pkg::VST_WARM_RISES
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    output logic done
);
    localparam int unsigned CW = $clog2(RISES + 1) + 1;
    localparam logic [CW-1:0] LIMIT = CW'(RISES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                         cnt <= '0;
        else if (count_en && cnt < LIMIT) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIMIT);
endmodule

// File: rtl/vst_serializer.sv
module vst_serializer
    import vst_pkg::*;
#(
    parameter int unsigned DEPTH  = VST_DEPTH,
    parameter int unsigned DATA_W = VST_DATA_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic                      advance,
    output logic [$clog2(DEPTH)-1:0]  rd_addr,
    input  logic [DATA_W-1:0]         rd_data,
    output logic                      drive,
    output logic                      bit_out
);
    localparam int unsigned ADDR_W = $clog2(DEPTH);
    localparam logic [3:0] SLOT_GAP  = 4'(DATA_W);
    localparam logic [3:0] SLOT_LAST = 4'(DATA_W - 1);

    ser_state_t        st_q;
    logic [DATA_W-1:0] shreg_q;
    logic [ADDR_W-1:0] addr_q;
    step_e             step;

    always_comb begin
        if (st_q.slot == SLOT_GAP)       step = STEP_LOAD;
        else if (st_q.slot == SLOT_LAST) step = STEP_GAP;
        else                             step = STEP_SHIFT;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st_q    <= '{drive: 1'b0, slot: SLOT_GAP};
            shreg_q <= '0;
            addr_q  <= '0;
        end else if (advance) begin
            unique case (step)
                STEP_LOAD: begin
                    shreg_q <= rd_data;
                    st_q    <= '{drive: 1'b1, slot: 4'd0};
                    addr_q  <= ADDR_W'(wrap_inc(int'(addr_q), DEPTH));
                end
                STEP_SHIFT: begin
                    shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
                    st_q    <= '{drive: 1'b1, slot: st_q.slot + 4'd1};
                end
                default: begin
                    st_q    <= '{drive: 1'b0, slot: SLOT_GAP};
                end
            endcase
        end
    end

    assign rd_addr = addr_q;
    assign drive   = st_q.drive;
    assign bit_out = shreg_q[DATA_W-1];
endmodule

// File: rtl/vclk_stream_tx.sv
module vclk_stream_tx
    import vst_pkg::*;
#(
    parameter int unsigned DEPTH       = VST_DEPTH,
    parameter int unsigned DATA_W      = VST_DATA_W,
    parameter int unsigned WARM_RISES  = VST_WARM_RISES,
    parameter int unsigned SYNC_STAGES = VST_SYNC_STAGES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vclk_in,
    input  logic                     en,
    output logic [$clog2(DEPTH)-1:0] rd_addr,
    input  logic [DATA_W-1:0]        rd_data,
    output logic                     sda_oe,
    output logic                     sda_out
);
    logic vclk_rise;
    logic warm_done;
    logic drive;

    vst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (vclk_in),
        .rise     (vclk_rise)
    );

    vst_warmup #(.RISES(WARM_RISES)) u_warm (
        .clk      (clk),
        .rst      (rst),
        .count_en (en & vclk_rise),
        .done     (warm_done)
    );

    vst_serializer #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .advance (vclk_rise & warm_done),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .drive   (drive),
        .bit_out (sda_out)
    );

    // release immediately when the mode controller withdraws the enable
    assign sda_oe = drive & en;
endmodule

// File: rtl/vst_checker.sv
module vst_checker #(
    parameter int unsigned DEPTH      = 128,
    parameter int unsigned WARM_RISES = 9
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     en,
    input logic                     vclk_rise,
    input logic                     sda_oe,
    input logic                     sda_out,
    input logic [$clog2(DEPTH)-1:0] rd_addr
);
    localparam int unsigned CW = $clog2(WARM_RISES + 2) + 1;
    logic [CW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= '0;
        else if (en && vclk_rise && seen <= CW'(WARM_RISES)) seen <= seen + 1'b1;
    end

    AST_WARM_SILENT: assert property (@(posedge clk) disable iff (rst)
        (seen <= CW'(WARM_RISES)) |-> !sda_oe); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_addr) |-> (rd_addr == $clog2(DEPTH)'($past(rd_addr) + 1'b1) || rd_addr == '0)); // R5

    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
        (en && !vclk_rise) |=> (!en || ($stable(sda_oe) && $stable(sda_out) && $stable(rd_addr)))); // R6

    AST_OFF_RESTART: assert property (@(posedge clk) disable iff (rst)
        !en |=> (rd_addr == '0 && !sda_oe)); // R7
endmodule

bind vclk_stream_tx vst_checker #(.DEPTH(DEPTH), .WARM_RISES(WARM_RISES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .vclk_rise (vclk_rise),
    .sda_oe    (sda_oe),
    .sda_out   (sda_out),
    .rd_addr   (rd_addr)
);

// File: tb/tb_vclk_stream_tx.sv
module tb_vclk_stream_tx;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 128;
    localparam int WARM       = 9;
    localparam int LAT        = 3;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vclk_in = 1'b0;
    logic       en = 1'b0;
    logic [6:0] rd_addr;
    logic [7:0] rd_data;
    logic       sda_oe, sda_out;
    logic [7:0] mem [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign rd_data = mem[rd_addr];

    vclk_stream_tx dut (
        .clk(clk), .rst(rst), .vclk_in(vclk_in), .en(en),
        .rd_addr(rd_addr), .rd_data(rd_data), .sda_oe(sda_oe), .sda_out(sda_out)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference: edges counted, bit position in the endless stream
    int m_warm = 0;
    int m_pos  = 0;
    bit exp_oe = 1'b0;
    bit exp_bit = 1'b0;
    int exp_addr = 0;
    bit mon_on = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_rise();
        if (!en) return;
        if (m_warm < WARM) begin
            m_warm++;
            exp_oe = 1'b0;
        end else begin
            int byte_i = (m_pos / 9) % DEPTH;
            int b = m_pos % 9;
            if (b < 8) begin
                exp_oe = 1'b1;
                exp_bit = mem[byte_i][7-b];
                if (b == 0) exp_addr = (byte_i + 1) % DEPTH;
            end else begin
                exp_oe = 1'b0;
            end
            m_pos++;
        end
    endtask

    task automatic vpulse(input int hi, input int lo);
        @(negedge clk);
        vclk_in = 1'b1;
        repeat (LAT) @(posedge clk);
        model_rise();
        repeat (hi) @(negedge clk);
        vclk_in = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic disable_stream();
        @(negedge clk);
        en = 1'b0;
        exp_oe = 1'b0;
        #2;
        chk(sda_oe == 1'b0, "R7", "sda_oe same cycle after en drop", int'(sda_oe), 0);
        @(posedge clk);
        exp_addr = 0;
        m_pos = 0;
    endtask

    task automatic enable_stream();
        @(negedge clk);
        en = 1'b1;
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (mon_on) begin
            #2;
            chk(sda_oe == exp_oe, (m_warm < WARM) ? "R2" : "R6", "sda_oe per cycle", int'(sda_oe), int'(exp_oe));
            if (exp_oe)
                chk(sda_out == exp_bit, "R4", "sda_out per cycle", int'(sda_out), int'(exp_bit));
            chk(int'(rd_addr) == exp_addr, "R9", "rd_addr per cycle", int'(rd_addr), exp_addr);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'((i * 37) ^ 8'hA5);

        repeat (5) @(negedge clk);
        #2;
        chk(sda_oe == 1'b0, "R1", "sda_oe in reset", int'(sda_oe), 0);
        chk(rd_addr == 7'd0, "R1", "rd_addr in reset", int'(rd_addr), 0);
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;
        @(negedge clk);
        #2;
        chk(sda_oe == 1'b0 && rd_addr == 7'd0, "R1", "state after reset", int'(sda_oe) + int'(rd_addr), 0);
        enable_stream();

        // warm-up interrupted by the enable: counter holds (R2)
        for (int k = 0; k < 5; k++) vpulse(4, 3);
        disable_stream();
        for (int k = 0; k < 6; k++) vpulse(4, 3);
        enable_stream();
        for (int k = 0; k < 4; k++) vpulse(4, 3);
        #3;
        chk(sda_oe == 1'b0, "R2", "released after ninth counted edge", int'(sda_oe), 0);

        // tenth counted edge: MSB of address 0 (R3)
        vpulse(4, 3);
        #3;
        chk(sda_oe == 1'b1, "R3", "drive on tenth edge", int'(sda_oe), 1);
        chk(sda_out == mem[0][7], "R3", "MSB of address 0", int'(sda_out), int'(mem[0][7]));
        chk(rd_addr == 7'd1, "R9", "address advanced with MSB", int'(rd_addr), 1);

        // full pass through the array and past the wrap (R4, R5)
        while (m_pos < 128 * 9 + 18) begin
            vpulse(4, 3);
            if (m_pos == 127 * 9 + 1) begin
                #3;
                chk(rd_addr == 7'd0, "R5", "address wraps after 127 loaded", int'(rd_addr), 0);
            end
            if (m_pos == 128 * 9) begin
                #3;
                chk(sda_oe == 1'b0, "R4", "null slot after last byte", int'(sda_oe), 0);
            end
            if (m_pos == 128 * 9 + 1) begin
                #3;
                chk(sda_oe == 1'b1 && sda_out == mem[0][7], "R5", "MSB of 0 right after 127",
                    int'(sda_out), int'(mem[0][7]));
            end
        end

        // stretched edges: outputs hold between rises (R6)
        for (int k = 0; k < 20; k++) vpulse(12, 15);
        // short high phase
        for (int k = 0; k < 12; k++) vpulse(1, 3);

        // mid-byte withdrawal and restart (R7, R8)
        while (m_pos % 9 != 4) vpulse(4, 3);
        disable_stream();
        for (int k = 0; k < 3; k++) vpulse(4, 3);
        #3;
        chk(sda_oe == 1'b0, "R7", "edges ignored while disabled", int'(sda_oe), 0);
        chk(rd_addr == 7'd0, "R7", "rd_addr cleared while disabled", int'(rd_addr), 0);
        enable_stream();
        vpulse(4, 3);
        #3;
        chk(sda_oe == 1'b1, "R8", "drives on first edge after re-enable", int'(sda_oe), 1);
        chk(sda_out == mem[0][7], "R8", "restart at MSB of address 0", int'(sda_out), int'(mem[0][7]));
        chk(rd_addr == 7'd1, "R8", "address after restart", int'(rd_addr), 1);
        for (int k = 0; k < 30; k++) vpulse(3, 4);

        mon_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule